// File: doc/BRIEF.md
# Accumulator Processor with 16-bit Instruction Words

This block is a small multi-cycle processor built around one 16-bit accumulator. Each instruction word has two parts. The top four bits select the operation. The low twelve bits are either an immediate value or a word address. The block reads instructions from an external word-addressed memory. It then decodes and executes them one at a time. Four operations are defined: load an immediate, subtract an immediate, store the accumulator to memory, and branch when the accumulator is non-zero. These are enough to run a countdown loop that subtracts, stores and branches back with no other support.

The memory port is a plain synchronous port. The memory is always ready and applies no back-pressure. A read returns the addressed word one cycle after the address is presented. A write takes effect at the clock edge where the write enable is high. Any opcode outside the four defined ones stops the processor, and the halt output stays high until reset.

Top module: `acc_cpu`

## Requirements
- R1: While reset is asserted and in the first cycle after it, halt is low, the write enable is low and the memory address is 0, because the program counter and accumulator clear to zero.
- R2: Bits [15:12] of an instruction word carry the opcode and bits [11:0] carry the operand field. Encodings: 0000 load, 0110 subtract, 0010 store, 0111 branch-if-non-zero.
- R3: Opcode 0000 sets the accumulator to the 12-bit operand, zero-extended to 16 bits.
- R4: Opcode 0110 sets the accumulator to the accumulator minus the zero-extended operand, wrapping modulo 2^16.
- R5: Opcode 0010 writes the accumulator to the memory word at the 12-bit address field, using a write enable that is high for exactly one cycle.
- R6: Opcode 0111 loads the program counter with the address field when the accumulator is non-zero. Otherwise the next sequential word executes.
- R7: Load, subtract, branch and undefined words each take 3 cycles (fetch, decode, execute). A store takes 4 cycles. Memory reads have one cycle of latency.
- R8: Any other opcode raises halt 3 cycles after its fetch. Halt then stays high with no further writes and a frozen memory address until reset.
- R9: A loop program that loads 0x0FFF, subtracts 5, stores to 0x333 and branches back to the subtract while the accumulator is non-zero performs 819 stores. The first stored value is 0x0FFA and the last is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 12 | Word address for instruction fetch or data store |
| mem_wdata | output | 16 | Store data (the accumulator) |
| mem_we | output | 1 | Write enable for one store cycle |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |
| halt | output | 1 | High once an undefined opcode has been executed |

## Verification
Every cycle, the assertions check four properties. Halt is sticky and blocks writes. A write pulse never lasts more than one cycle. The accumulator holds unless a load or subtract executes. A branch that is not taken leaves the incremented program counter alone.

Only the bench scenarios can show the rest: the values written to memory, the cycle count of each instruction mix, the wrap of subtraction below zero, and the full countdown loop. These are compared against an instruction-level model that runs random and directed programs.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_LDA = 4'b0000;
  localparam logic [OPC_W-1:0] OPC_STA = 4'b0010;
  localparam logic [OPC_W-1:0] OPC_SUB = 4'b0110;
  localparam logic [OPC_W-1:0] OPC_JNZ = 4'b0111;

  typedef enum logic [2:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_EXEC   = 3'd2,
    ST_STORE  = 3'd3,
    ST_HALT   = 3'd4
  } cpu_state_e;

  typedef struct packed {
    logic ld;
    logic sub;
    logic st;
    logic jnz;
    logic bad;
  } dec_t;
endpackage

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
  import acc_cpu_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int FIELD_W = WORD_W - OPC_W
) (
  input  logic [WORD_W-1:0]  instr,
  output dec_t               dec,
  output logic [FIELD_W-1:0] field
);
  logic [OPC_W-1:0] opc;

  // R2: opcode sits in the top bits, operand field below it
  assign opc   = instr[WORD_W-1 -: OPC_W];
  assign field = instr[FIELD_W-1:0];

  always_comb begin
    dec = '0;
    case (opc)
      OPC_LDA: dec.ld  = 1'b1;
      OPC_SUB: dec.sub = 1'b1;
      OPC_STA: dec.st  = 1'b1;
      OPC_JNZ: dec.jnz = 1'b1;
      default: dec.bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
  parameter int WORD_W  = 16,
  parameter int FIELD_W = 12,
  localparam int EXT_W  = WORD_W - FIELD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic               sub_en,
  input  logic [FIELD_W-1:0] field,
  output logic [WORD_W-1:0]  acc,
  output logic               acc_zero
);
  logic [WORD_W-1:0] imm;

  assign imm = {{EXT_W{1'b0}}, field};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc <= '0;
    else if (load_en) acc <= imm;
    else if (sub_en)  acc <= acc - imm;
  end

  assign acc_zero = (acc == '0);

  assert_acc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_en || sub_en) |=> $stable(acc))
    else $error("accumulator changed without load or subtract");
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int FIELD_W = WORD_W - OPC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WORD_W-1:0]  mem_rdata,
  input  dec_t               dec,
  input  logic [FIELD_W-1:0] field,
  input  logic               acc_zero,
  output logic [WORD_W-1:0]  ir,
  output logic               load_en,
  output logic               sub_en,
  output logic [FIELD_W-1:0] mem_addr,
  output logic               mem_we,
  output logic               halt
);
  cpu_state_e         state;
  logic [FIELD_W-1:0] pc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_FETCH;
      pc    <= '0;
      ir    <= '0;
    end else begin
      case (state)
        ST_FETCH:  state <= ST_DECODE;
        ST_DECODE: begin
          ir    <= mem_rdata;
          pc    <= pc + 1'b1;
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          if (dec.bad)      state <= ST_HALT;
          else if (dec.st)  state <= ST_STORE;
          else begin
            if (dec.jnz && !acc_zero) pc <= field;
            state <= ST_FETCH;
          end
        end
        ST_STORE:  state <= ST_FETCH;
        default:   state <= ST_HALT;
      endcase
    end
  end

  assign load_en  = (state == ST_EXEC) && dec.ld;
  assign sub_en   = (state == ST_EXEC) && dec.sub;
  assign mem_we   = (state == ST_STORE);
  assign mem_addr = (state == ST_STORE) ? field : pc;
  assign halt     = (state == ST_HALT);

  assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt)
    else $error("halt dropped without reset");

  assert_halt_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !mem_we)
    else $error("write while halted");

  assert_single_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we)
    else $error("write enable held longer than one cycle");

  assert_jnz_fallthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && dec.jnz && acc_zero) |=> (pc == $past(pc)))
    else $error("branch taken with zero accumulator");
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int FIELD_W = WORD_W - OPC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [FIELD_W-1:0] mem_addr,
  output logic [WORD_W-1:0]  mem_wdata,
  output logic               mem_we,
  input  logic [WORD_W-1:0]  mem_rdata,
  output logic               halt
);
  dec_t               dec;
  logic [FIELD_W-1:0] field;
  logic [WORD_W-1:0]  ir;
  logic [WORD_W-1:0]  acc;
  logic               acc_zero;
  logic               load_en;
  logic               sub_en;

  acc_cpu_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_rdata(mem_rdata),
    .dec      (dec),
    .field    (field),
    .acc_zero (acc_zero),
    .ir       (ir),
    .load_en  (load_en),
    .sub_en   (sub_en),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .halt     (halt)
  );

  acc_cpu_decode #(.WORD_W(WORD_W)) u_decode (
    .instr(ir),
    .dec  (dec),
    .field(field)
  );

  acc_cpu_alu #(.WORD_W(WORD_W), .FIELD_W(FIELD_W)) u_alu (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (load_en),
    .sub_en  (sub_en),
    .field   (field),
    .acc     (acc),
    .acc_zero(acc_zero)
  );

  assign mem_wdata = acc;
endmodule

// File: tb/acc_cpu_tb.sv
`timescale 1ns/1ps
module acc_cpu_tb;
  localparam int WORD_W = 16;
  localparam int MEM_N  = 4096;
  localparam logic [15:0] FILL = 16'hA5A5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic [15:0] mem_rdata = '0;
  logic        halt;

  always #4 clk = ~clk;

  acc_cpu #(.WORD_W(WORD_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .halt(halt)
  );

  logic [15:0] mem     [MEM_N];
  logic [15:0] ref_mem [MEM_N];
  logic        ld_en = 1'b0;
  logic [11:0] ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic        mon_clr = 1'b0;
  int          st333_cnt = 0;
  logic [15:0] st333_first = '0;
  logic        dbl_we = 1'b0;
  logic        prev_we = 1'b0;

  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
    if (mon_clr) begin
      st333_cnt <= 0; dbl_we <= 1'b0; prev_we <= 1'b0;
    end else begin
      prev_we <= mem_we;
      if (mem_we && prev_we) dbl_we <= 1'b1;
      if (mem_we && mem_addr == 12'h333) begin
        if (st333_cnt == 0) st333_first <= mem_wdata;
        st333_cnt <= st333_cnt + 1;
      end
    end
  end

  int checks = 0;
  int fails  = 0;
  logic [3:0] bad_ops [12];

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic put(int a, logic [15:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = a[11:0]; ld_data = d;
    @(posedge clk); #1;
    ld_en = 1'b0;
    ref_mem[a] = d;
  endtask

  task automatic prep();
    @(negedge clk);
    rst_n = 1'b0;
    mon_clr = 1'b1;
    for (int i = 0; i < 16; i++) put(12'h800 + i, FILL);
    put(12'h333, FILL);
  endtask

  // instruction-level reference model; returns expected cycles to halt
  task automatic ref_run(output int cyc);
    logic [11:0] pc;
    logic [15:0] acc, w, imm;
    bit done;
    pc = '0; acc = '0; cyc = 0; done = 0;
    for (int g = 0; g < 100000 && !done; g++) begin
      w = ref_mem[pc];
      imm = {4'h0, w[11:0]};
      pc = pc + 12'd1;
      case (w[15:12])
        4'b0000: begin acc = imm;       cyc += 3; end
        4'b0110: begin acc = acc - imm; cyc += 3; end
        4'b0010: begin ref_mem[w[11:0]] = acc; cyc += 4; end
        4'b0111: begin if (acc != 0) pc = w[11:0]; cyc += 3; end
        default: begin cyc += 3; done = 1; end
      endcase
    end
  endtask

  task automatic run(string req);
    int exp_cyc, cyc;
    logic [11:0] a0;
    bit frz_bad;
    ref_run(exp_cyc);
    @(negedge clk);
    // R1: state under reset
    chk(!halt && !mem_we && mem_addr == 0, "R1", "reset outputs",
        {halt, mem_we, mem_addr}, 32'h0);
    mon_clr = 1'b0;
    rst_n = 1'b1;
    #1;
    chk(mem_addr == 0 && !mem_we, "R1", "first fetch address", mem_addr, 0);
    cyc = 0;
    while (!halt && cyc < 50000) begin
      @(posedge clk); #1;
      cyc++;
    end
    chk(cyc == exp_cyc, "R7", {req, " cycles to halt"}, cyc, exp_cyc);
    for (int i = 0; i < 16; i++)
      chk(mem[12'h800 + i] == ref_mem[12'h800 + i], req, "data word",
          mem[12'h800 + i], ref_mem[12'h800 + i]);
    chk(mem[12'h333] == ref_mem[12'h333], req, "word 0x333", mem[12'h333], ref_mem[12'h333]);
    a0 = mem_addr;
    frz_bad = 0;
    repeat (8) begin
      @(posedge clk); #1;
      if (mem_we || !halt || mem_addr != a0) frz_bad = 1;
    end
    chk(!frz_bad, "R8", "halt freeze", frz_bad, 0);
    chk(!dbl_we, "R5", "single-cycle write pulse", dbl_we, 0);
    @(negedge clk);
    rst_n = 1'b0;
  endtask

  initial begin
    int n, seed_d, len, r;
    logic [15:0] w;
    begin
      n = 0;
      for (int op = 0; op < 16; op++)
        if (op != 0 && op != 2 && op != 6 && op != 7) begin
          bad_ops[n] = op[3:0]; n++;
        end
    end
    seed_d = $urandom(32'd20240607);

    // R3 R4: zero extension and wrap below zero
    prep();
    put(0, 16'h0003); put(1, 16'h6005); put(2, 16'h2800);
    put(3, 16'h0FFF); put(4, 16'h2801); put(5, 16'hF000);
    run("R4");
    chk(mem[12'h800] == 16'hFFFE, "R4", "3-5 wraps", mem[12'h800], 16'hFFFE);
    chk(mem[12'h801] == 16'h0FFF, "R3", "zero-extended load", mem[12'h801], 16'h0FFF);

    // R6: branch not taken with zero accumulator
    prep();
    put(0, 16'h0000); put(1, 16'h7004); put(2, 16'h0009);
    put(3, 16'h2802); put(4, 16'h1000);
    run("R6");
    chk(mem[12'h802] == 16'h0009, "R6", "fall-through executed", mem[12'h802], 16'h0009);

    // R6: branch taken skips a store
    prep();
    put(0, 16'h0001); put(1, 16'h7003); put(2, 16'h2803); put(3, 16'hE000);
    run("R6");
    chk(mem[12'h803] == FILL, "R6", "skipped store untouched", mem[12'h803], FILL);

    // R9: countdown loop, 8202 cycles expected
    prep();
    put(0, 16'h0001); put(1, 16'h7101);
    put(12'h101, 16'h0FFF); put(12'h102, 16'h6005); put(12'h103, 16'h2333);
    put(12'h104, 16'h7102); put(12'h105, 16'hF000);
    run("R9");
    chk(st333_cnt == 819, "R9", "store count", st333_cnt, 819);
    chk(st333_first == 16'h0FFA, "R9", "first stored value", st333_first, 16'h0FFA);
    chk(mem[12'h333] == 16'h0000, "R9", "final stored value", mem[12'h333], 0);

    // R8: every undefined opcode halts, a store after it never happens
    for (int k = 0; k < 12; k++) begin
      prep();
      put(0, 16'h0005); put(1, {bad_ops[k], 12'h800}); put(2, 16'h2800);
      run("R8");
      chk(mem[12'h800] == FILL, "R8", "no store after undefined opcode", mem[12'h800], FILL);
    end

    // R2 R3 R4 R5 R6 R7: random forward-branching programs
    for (int t = 0; t < 40; t++) begin
      prep();
      len = 6 + ($urandom % 20);
      for (int i = 0; i < len; i++) begin
        r = $urandom % 4;
        case (r)
          0: w = {4'b0000, 12'($urandom)};
          1: w = {4'b0110, 12'($urandom)};
          2: w = {4'b0010, 12'h800 + 12'($urandom % 16)};
          default: w = {4'b0111, 12'(i + 1 + ($urandom % (len - i)))};
        endcase
        put(i, w);
      end
      put(len, {bad_ops[$urandom % 12], 12'($urandom)});
      run("R5");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule